// File: doc/BRIEF.md
# GPIO Port Controller with Pad Readback

This block controls a bank of general-purpose pads grouped into ports of sixteen pads each, two ports by default. Software reaches it over a simple register bus with byte enables. It stores an output value, a direction bit, a function select and a drive-type select for every pad. Output data is kept apart from input data. The input word always shows the level actually present on each pad, after a two-flop synchronizer, and never the value last written.

Each pad is either a GPIO or hands its output and output-enable to an alternate peripheral. In GPIO mode the pad drives push-pull or open-drain. Output values written while a pad belongs to its peripheral are kept, and they appear on the pad once it returns to GPIO. Any mix of byte lanes may be written, so software can update half a port, a whole port or both ports in one access.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every stored output value is 0, every pad is a GPIO input (direction 0, pad_oe 0) and every pad is push-pull.
- R2: The input word (word address 1) reads the pad_in levels two clock edges after they are applied. Before that it still shows the earlier levels.
- R3: Writes to the input word address change no register. The input word keeps reading the pad levels.
- R4: The input word reflects pad levels whether a pad is in GPIO or in alternate mode.
- R5: A write to output data while a pad is in alternate mode updates the stored value and reads back at once. The pad does not drive it. When the pad returns to GPIO, the stored value is driven.
- R6: In GPIO push-pull mode (drive bit 0), pad_out equals the stored output bit and pad_oe equals the direction bit (1 = output).
- R7: In GPIO open-drain mode (drive bit 1), pad_out is 0. pad_oe is 1 only when the direction bit is 1 and the stored bit is 0, so a stored 1 releases the pad.
- R8: In alternate mode (mode bit 1), pad_out and pad_oe equal alt_out and alt_oe for that pad.
- R9: Lane mapping: word bits 31..16 hold port 0 pads 15..0, and word bits 15..0 hold port 1 pads 15..0. Port 0 is pads 0..15 of the pad vectors and port 1 is pads 16..31. bus_be[3] qualifies bits 31..24, which is the lowest byte address and the upper half of port 0. bus_be[0] qualifies bits 7..0.
- R10: A write updates only the bits of lanes whose byte enable is set. Bits in the other lanes keep their values.
- R11: Word addresses are 0 output data, 1 input data, 2 direction, 3 mode, 4 drive type. Addresses 5 to 7 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, qualifies writes |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Pad levels, pad-ordered |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| alt_out | input | 32 | Peripheral output per pad |
| alt_oe | input | 32 | Peripheral output enable per pad |

## Verification
The bench builds the block with its defaults: two ports of sixteen pads. At that size every pad and every byte-enable pattern can be swept completely. All sixteen byte-enable combinations are merged against a reference word. A walking one crosses all thirty-two pad inputs, so the lane swap between ports and the two-clock synchronizer lag are each checked at every bit. Drive type, direction and mode patterns cover push-pull, open-drain and alternate ownership on both ports at once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DOUT = 3'd0,
    REG_DIN  = 3'd1,
    REG_DIR  = 3'd2,
    REG_MODE = 3'd3,
    REG_DRV  = 3'd4
  } gpio_reg_e;

  // Writable registers, in bank order
  localparam int NUM_WR = 4;

  function automatic gpio_reg_e wr_slot_addr(input int slot);
    case (slot)
      0:       return REG_DOUT;
      1:       return REG_DIR;
      2:       return REG_MODE;
      default: return REG_DRV;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_mask,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= (q & ~wr_mask) | (wr_data & wr_mask);
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int N = 32
) (
  input  logic [N-1:0] mode_alt,
  input  logic [N-1:0] open_drain,
  input  logic [N-1:0] dir_out,
  input  logic [N-1:0] dout,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);

  for (genvar i = 0; i < N; i++) begin : g_pad
    always_comb begin
      if (mode_alt[i]) begin
        pad_out[i] = alt_out[i];
        pad_oe[i]  = alt_oe[i];
      end else if (open_drain[i]) begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = dir_out[i] & ~dout[i];
      end else begin
        pad_out[i] = dout[i];
        pad_oe[i]  = dir_out[i];
      end
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_PORTS*PORT_W/8-1:0] bus_be,
  input  logic [NUM_PORTS*PORT_W-1:0]   bus_wdata,
  output logic [NUM_PORTS*PORT_W-1:0]   bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pad_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_oe,
  input  logic [NUM_PORTS*PORT_W-1:0]   alt_out,
  input  logic [NUM_PORTS*PORT_W-1:0]   alt_oe
);

  localparam int NUM_PAD = NUM_PORTS * PORT_W;
  localparam int WORD_W  = NUM_PAD;
  localparam int BE_W    = WORD_W / 8;

  // Port k sits at word slice (NUM_PORTS-1-k): lowest port in the top lanes
  function automatic logic [NUM_PAD-1:0] word_to_pads(input logic [WORD_W-1:0] w);
    logic [NUM_PAD-1:0] r;
    for (int k = 0; k < NUM_PORTS; k++)
      for (int p = 0; p < PORT_W; p++)
        r[k*PORT_W+p] = w[(NUM_PORTS-1-k)*PORT_W+p];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] pads_to_word(input logic [NUM_PAD-1:0] v);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < NUM_PORTS; k++)
      for (int p = 0; p < PORT_W; p++)
        r[(NUM_PORTS-1-k)*PORT_W+p] = v[k*PORT_W+p];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] lanes_to_bits(input logic [BE_W-1:0] be);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < BE_W; b++) r[b*8 +: 8] = {8{be[b]}};
    return r;
  endfunction

  // Named internal events and state, visible to the checker
  logic               wr_hit;
  logic [NUM_PAD-1:0] wr_mask_pads;
  logic [NUM_PAD-1:0] wr_data_pads;
  logic [NUM_PAD-1:0] bank_q [NUM_WR];
  logic [NUM_PAD-1:0] dout_q, dir_q, mode_q, drv_q, din_q;

  assign wr_hit       = bus_valid & bus_write;
  assign wr_mask_pads = word_to_pads(lanes_to_bits(bus_be));
  assign wr_data_pads = word_to_pads(bus_wdata);

  for (genvar i = 0; i < NUM_WR; i++) begin : g_bank
    gpio_reg_bank #(.N(NUM_PAD)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hit && (bus_addr == wr_slot_addr(i))),
      .wr_mask (wr_mask_pads),
      .wr_data (wr_data_pads),
      .q       (bank_q[i])
    );
  end

  assign dout_q = bank_q[0];
  assign dir_q  = bank_q[1];
  assign mode_q = bank_q[2];
  assign drv_q  = bank_q[3];

  gpio_sync #(.N(NUM_PAD), .STAGES(2)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (din_q)
  );

  gpio_pad_drive #(.N(NUM_PAD)) drive_i (
    .mode_alt   (mode_q),
    .open_drain (drv_q),
    .dir_out    (dir_q),
    .dout       (dout_q),
    .alt_out    (alt_out),
    .alt_oe     (alt_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  always_comb begin
    case (bus_addr)
      REG_DOUT: bus_rdata = pads_to_word(dout_q);
      REG_DIN:  bus_rdata = pads_to_word(din_q);
      REG_DIR:  bus_rdata = pads_to_word(dir_q);
      REG_MODE: bus_rdata = pads_to_word(mode_q);
      REG_DRV:  bus_rdata = pads_to_word(drv_q);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PAD = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_PAD-1:0] pad_in,
  input logic [NUM_PAD-1:0] pad_out,
  input logic [NUM_PAD-1:0] pad_oe,
  input logic [NUM_PAD-1:0] alt_out,
  input logic [NUM_PAD-1:0] alt_oe,
  input logic [NUM_PAD-1:0] dout_q,
  input logic [NUM_PAD-1:0] din_q,
  input logic [NUM_PAD-1:0] dir_q,
  input logic [NUM_PAD-1:0] mode_q,
  input logic [NUM_PAD-1:0] drv_q
);

  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  logic gpio_pp_ok, gpio_od_ok, alt_ok;
  assign gpio_pp_ok = (((pad_out ^ dout_q) | (pad_oe ^ dir_q)) & ~mode_q & ~drv_q) == '0;
  assign gpio_od_ok = ((pad_out | (pad_oe & dout_q)) & ~mode_q & drv_q) == '0;
  assign alt_ok     = (((pad_out ^ alt_out) | (pad_oe ^ alt_oe)) & mode_q) == '0;

  // R2, R4: input state lags the pad by two edges
  a_r2_din_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (din_q == $past(pad_in, 2)));

  // R3, R11: a write to the input address leaves every stored register alone
  a_r3_din_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == REG_DIN) |=>
      ($stable(dout_q) && $stable(dir_q) && $stable(mode_q) && $stable(drv_q)));

  // R5, R10: output data moves only on a write to its own address
  a_r5_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == REG_DOUT) |=> $stable(dout_q));

  // R6
  a_r6_push_pull: assert property (@(posedge clk) disable iff (!rst_n) gpio_pp_ok);
  // R7
  a_r7_open_drain: assert property (@(posedge clk) disable iff (!rst_n) gpio_od_ok);
  // R8
  a_r8_alt_pass: assert property (@(posedge clk) disable iff (!rst_n) alt_ok);

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PAD(NUM_PAD)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .alt_out   (alt_out),
  .alt_oe    (alt_oe),
  .dout_q    (dout_q),
  .din_q     (din_q),
  .dir_q     (dir_q),
  .mode_q    (mode_q),
  .drv_q     (drv_q)
);

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [31:0] alt_out = '0;
  logic [31:0] alt_oe = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe)
  );

  // Word -> pad order: port 0 (pads 15..0) lives in word bits 31..16, so swap halves
  function automatic logic [31:0] w2p(input logic [31:0] w);
    return {w[15:0], w[31:16]};
  endfunction

  function automatic logic [31:0] be_bits(input logic [3:0] be);
    logic [31:0] r = '0;
    if (be[0]) r = r | 32'h0000_00FF;
    if (be[1]) r = r | 32'h0000_FF00;
    if (be[2]) r = r | 32'h00FF_0000;
    if (be[3]) r = r | 32'hFF00_0000;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v, base, d2, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 dout", v, '0);
    rd(3'd2, v); check("R1 dir", v, '0);
    rd(3'd3, v); check("R1 mode", v, '0);
    rd(3'd4, v); check("R1 drv", v, '0);
    check("R1 pad_oe", pad_oe, '0);

    // R11 unmapped addresses read zero, writes ignored
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 4'hF, 32'hFFFF_FFFF);
      rd(3'(a), v); check("R11 unmapped", v, '0);
    end
    rd(3'd0, v); check("R11 dout after unmapped write", v, '0);

    // R9/R10 exhaustive byte-enable sweep, push-pull outputs
    wr(3'd2, 4'hF, 32'hFFFF_FFFF);
    base = 32'hA5C3_3C5A;
    for (int be = 0; be < 16; be++) begin
      wr(3'd0, 4'hF, base);
      d2 = 32'h1234_5678 ^ (32'(be) * 32'h0101_0101);
      wr(3'd0, 4'(be), d2);
      exp = (base & ~be_bits(4'(be))) | (d2 & be_bits(4'(be)));
      rd(3'd0, v); check("R10 dout merge", v, exp);
      check("R9 pad_out lanes", pad_out, w2p(exp));
    end

    // R2 walking one over every pad, with the two-edge lag
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      pad_in = 32'h1 << n;
      @(negedge clk);
      if (n == 0) begin
        rd(3'd1, v); check("R2 lag one edge", v, '0);
      end
      @(negedge clk);
      rd(3'd1, v);
      check("R2 din walk", w2p(v), pad_in);
    end

    // R3 input address is read-only
    wr(3'd2, 4'hF, 32'h0F0F_F0F0);
    wr(3'd0, 4'hF, 32'h3333_CCCC);
    wr(3'd1, 4'hF, 32'h0000_0000);
    wr(3'd1, 4'hF, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R3 dout kept", v, 32'h3333_CCCC);
    rd(3'd2, v); check("R3 dir kept", v, 32'h0F0F_F0F0);
    rd(3'd3, v); check("R3 mode kept", v, '0);
    rd(3'd4, v); check("R3 drv kept", v, '0);
    rd(3'd1, v); check("R3 din is pad", w2p(v), pad_in);

    // R6 push-pull
    check("R6 pad_out", pad_out, w2p(32'h3333_CCCC));
    check("R6 pad_oe", pad_oe, w2p(32'h0F0F_F0F0));

    // R7 open-drain on every pad
    wr(3'd4, 4'hF, 32'hFFFF_FFFF);
    check("R7 pad_out low", pad_out, '0);
    check("R7 pad_oe", pad_oe, w2p(32'h0F0F_F0F0 & ~32'h3333_CCCC));
    wr(3'd4, 4'hF, 32'h0000_0000);

    // R8/R4 alternate mode on port 0 only (word bits 31..16)
    alt_out = 32'h5A5A_A5A5; alt_oe = 32'hC3C3_3C3C;
    wr(3'd3, 4'hC, 32'hFFFF_0000);
    exp = w2p(32'h3333_CCCC);
    check("R8 pad_out mixed", pad_out, (alt_out & 32'h0000_FFFF) | (exp & 32'hFFFF_0000));
    check("R8 pad_oe mixed", pad_oe,
          (alt_oe & 32'h0000_FFFF) | (w2p(32'h0F0F_F0F0) & 32'hFFFF_0000));
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    rd(3'd1, v); check("R4 din in alt mode", w2p(v), 32'hDEAD_BEEF);

    // R5 write while alt: stored, not driven, then driven after return to GPIO
    wr(3'd0, 4'hF, 32'hCCCC_3333);
    rd(3'd0, v); check("R5 stored readback", v, 32'hCCCC_3333);
    check("R5 not driven in alt", pad_out & 32'h0000_FFFF, alt_out & 32'h0000_FFFF);
    wr(3'd3, 4'hF, 32'h0000_0000);
    check("R5 driven after return", pad_out, w2p(32'hCCCC_3333));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule